// File: doc/BRIEF.md
# PLL Serial Scan-Chain Reconfiguration Controller

This block writes a new configuration into the serial scan chain of a phase-locked loop and then commits it. The host side is register-like. A configuration vector of `CHAIN_LEN` bits sits on `cfg_i`, and a one-cycle `load_i` strobe starts a full load. A one-cycle `rewrite_i` strobe commits the data already held in the chain again, without shifting. That second path is how an output clock phase is stepped. `busy_o` is high while a command runs, `done_o` pulses once when the command ends, and `err_o` reports that the PLL never answered.

The scan-chain side produces a scan clock by dividing the system clock. The clock toggles every `HALF_DIV` system cycles and runs only while bits are being shifted or while the controller waits for the commit to finish.

A load works in this order:
- The read-enable goes high, then a zero is clocked in, followed by the vector, most significant bit first.
- Before the last bit is clocked, the read-enable is swapped for the write-enable.
- The write-enable is held with the clock stopped until the PLL raises its done flag.
- The write-enable is then released, and the clock keeps pulsing until the done flag falls, however long that takes.

A programmable limit bounds each wait for the done flag, so a PLL that never responds cannot hang the controller.

Top module: `pll_scan_loader`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `scan_clk_o`, `scan_read_o` and `scan_write_o` are low, and `done_o` and `err_o` are low after reset.
- R2: A load sends exactly `CHAIN_LEN+1` bits, one per rising edge of `scan_clk_o`. The first bit is 0, then `cfg_i` follows from bit `CHAIN_LEN-1` down to bit 0. `scan_read_o` is high, and `scan_write_o` low, at every rising edge except the last one.
- R3: At the rising edge that clocks the final configuration bit, `scan_read_o` is low and `scan_write_o` is high. The two are never high together.
- R4: After the final bit, `scan_write_o` stays high and `scan_clk_o` has no rising edge until `scan_done_i` is high.
- R5: Once `scan_done_i` is high, `scan_write_o` goes low and `scan_clk_o` keeps pulsing. The command ends at the first falling scan-clock edge at which `scan_done_i` is low. The number of pulses follows the PLL and is not fixed.
- R6: `rewrite_i` in idle raises `scan_write_o` with no scan-clock edge and no `scan_read_o`, then completes as in R4 and R5.
- R7: If `scan_done_i` does not change within `timeout_i` system cycles of a wait starting (rising in the first wait, falling in the second), the controller drops `scan_write_o` and `scan_clk_o`, sets `err_o`, and returns to idle with a `done_o` pulse. `err_o` clears when the next command is accepted.
- R8: `load_i` and `rewrite_i` are ignored while `busy_o` is high, including any change of `cfg_i`. The running load sends the vector captured at its start.
- R9: When `load_i` and `rewrite_i` are both high in an idle cycle, the load is performed.
- R10: `scan_clk_o` has a period of `2*HALF_DIV` system cycles, and `scan_data_o` changes only at falling scan-clock edges.
- R11: `done_o` is high for exactly one cycle, and that is the first cycle in which `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | CHAIN_LEN | Configuration vector, captured on an accepted load |
| load_i | input | 1 | Start a full load and commit |
| rewrite_i | input | 1 | Commit the stored chain contents again (phase step) |
| timeout_i | input | TMO_W | Limit, in system cycles, on each wait for `scan_done_i` |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_o | output | 1 | Last command timed out |
| scan_clk_o | output | 1 | Scan-chain clock |
| scan_data_o | output | 1 | Serial scan data |
| scan_read_o | output | 1 | Scan read-enable |
| scan_write_o | output | 1 | Scan write-enable |
| scan_done_i | input | 1 | Commit-complete flag from the PLL |

## Verification
Two host commands can arrive in the same idle cycle: a full load and a rewrite-only request. The bench provokes this by raising both strobes on one edge, both in a directed case and again as strobes sent in the middle of a running load.

The outcome is judged at the chain, not from internal state. The bench model counts exactly `CHAIN_LEN+1` captured rising edges and compares the captured stream with a leading zero followed by the vector. This shows that the load was chosen and that the rewrite neither cut the shift short nor started a second command.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_SHIFT   = 2'd1,
        PS_WAIT_HI = 2'd2,
        PS_WAIT_LO = 2'd3
    } psl_state_e;

endpackage

// File: rtl/psl_clk_div.sv
module psl_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(HALF_DIV - 1));
    assign tick_o = en_i && at_end;

    always_comb begin
        if (!en_i || at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/psl_wait_timer.sv
module psl_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired_o = run_i && (cnt_q >= limit_i);

    always_comb begin
        if (!run_i || clr_i) begin
            cnt_d = '0;
        end else if (cnt_q != '1) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pll_scan_loader.sv
module pll_scan_loader
    import pll_scan_pkg::*;
#(
    parameter int CHAIN_LEN = 75,
    parameter int HALF_DIV  = 2,
    parameter int TMO_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CHAIN_LEN-1:0] cfg_i,
    input  logic                 load_i,
    input  logic                 rewrite_i,
    input  logic [TMO_W-1:0]     timeout_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 scan_clk_o,
    output logic                 scan_data_o,
    output logic                 scan_read_o,
    output logic                 scan_write_o,
    input  logic                 scan_done_i
);
    localparam int NBITS = CHAIN_LEN + 1;
    localparam int RW    = $clog2(NBITS + 1);

    typedef struct packed {
        psl_state_e       st;
        logic [NBITS-1:0] sh;
        logic [RW-1:0]    rem;
        logic             sclk;
        logic             rd;
        logic             wr;
        logic             done;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick, tmo, clk_en, wait_run, wait_clr;

    assign clk_en   = (r_q.st == PS_SHIFT) || (r_q.st == PS_WAIT_LO);
    assign wait_run = (r_q.st == PS_WAIT_HI) || (r_q.st == PS_WAIT_LO);
    assign wait_clr = (r_d.st != r_q.st);

    psl_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (clk_en),
        .tick_o (tick)
    );

    psl_wait_timer #(.W(TMO_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wait_run),
        .clr_i     (wait_clr),
        .limit_i   (timeout_i),
        .expired_o (tmo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            PS_IDLE: begin
                if (load_i) begin
                    r_d.st   = PS_SHIFT;
                    r_d.sh   = {1'b0, cfg_i};
                    r_d.rem  = RW'(NBITS);
                    r_d.rd   = 1'b1;
                    r_d.wr   = 1'b0;
                    r_d.sclk = 1'b0;
                    r_d.err  = 1'b0;
                end else if (rewrite_i) begin
                    r_d.st  = PS_WAIT_HI;
                    r_d.wr  = 1'b1;
                    r_d.err = 1'b0;
                end
            end
            PS_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        r_d.rem  = r_q.rem - 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.rem == '0) begin
                            r_d.st = PS_WAIT_HI;
                        end else begin
                            r_d.sh = r_q.sh << 1;
                            if (r_q.rem == RW'(1)) begin
                                r_d.rd = 1'b0;
                                r_d.wr = 1'b1;
                            end
                        end
                    end
                end
            end
            PS_WAIT_HI: begin
                if (scan_done_i) begin
                    r_d.wr = 1'b0;
                    r_d.st = PS_WAIT_LO;
                end else if (tmo) begin
                    r_d.wr   = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = PS_IDLE;
                end
            end
            PS_WAIT_LO: begin
                if (tick && r_q.sclk && !scan_done_i) begin
                    r_d.sclk = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = PS_IDLE;
                end else if (tmo) begin
                    r_d.sclk = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = PS_IDLE;
                end else if (tick) begin
                    r_d.sclk = ~r_q.sclk;
                end
            end
            default: begin
                r_d.st = PS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: PS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != PS_IDLE);
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
    assign scan_clk_o   = r_q.sclk;
    assign scan_data_o  = r_q.sh[NBITS-1];
    assign scan_read_o  = r_q.rd;
    assign scan_write_o = r_q.wr;
endmodule

// File: rtl/psl_checker.sv
module psl_checker
    import pll_scan_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic       sdata,
    input logic       rd,
    input logic       wr,
    input logic       sdone,
    input psl_state_e state
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !rd && !wr)); // R1

    AST_RD_ONLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> (state == PS_SHIFT)); // R2

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr)); // R3

    AST_NO_CLK_WAIT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT_HI) |-> !sclk); // R4

    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT_HI && wr && !sdone) |=> (wr || !busy)); // R4

    AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11
endmodule

bind pll_scan_loader psl_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_o),
    .done  (done_o),
    .sclk  (scan_clk_o),
    .sdata (scan_data_o),
    .rd    (scan_read_o),
    .wr    (scan_write_o),
    .sdone (scan_done_i),
    .state (r_q.st)
);

// File: tb/sim_pll_scan_loader.sv
module sim_pll_scan_loader;
    localparam int L    = 174;
    localparam int HALF = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [L-1:0] cfg = '0;
    logic         load = 1'b0, rw = 1'b0;
    logic [15:0]  tmo = 16'd2000;
    logic         busy, done, err, sclk, sdata, rd, wr;
    logic         sdone = 1'b0;

    always #4 clk = ~clk;

    pll_scan_loader #(.CHAIN_LEN(L), .HALF_DIV(HALF), .TMO_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .load_i(load), .rewrite_i(rw),
        .timeout_i(tmo), .busy_o(busy), .done_o(done), .err_o(err),
        .scan_clk_o(sclk), .scan_data_o(sdata), .scan_read_o(rd),
        .scan_write_o(wr), .scan_done_i(sdone)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // PLL chain model and observation counters
    int dly_hi = 10, npulse = 3, mcnt = 0, mpul = 0;
    bit no_rise = 1'b0, no_fall = 1'b0;
    logic psclk = 1'b0;
    int cyc = 0, n_rise = 0, n_early_bad = 0, n_waitrise = 0, n_post = 0;
    int rise_t0 = 0, rise_t1 = 0, rd_cnt = 0, done_cnt = 0;
    logic fin_rd = 1'b0, fin_wr = 1'b0;
    logic [L:0] cap = '0;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        psclk <= sclk;
        if (done) done_cnt <= done_cnt + 1;
        if (rd) rd_cnt <= rd_cnt + 1;
        if (sclk && !psclk) begin
            if (rd || wr) begin
                cap    <= {cap[L-1:0], sdata};
                n_rise <= n_rise + 1;
                if (n_rise == 0) rise_t0 <= cyc;
                if (n_rise == 1) rise_t1 <= cyc;
                if (!(rd && !wr)) n_early_bad <= n_early_bad + 1;
                fin_rd <= rd;
                fin_wr <= wr;
            end
            if (wr && !sdone) n_waitrise <= n_waitrise + 1;
            if (sdone && !wr) n_post <= n_post + 1;
        end
        if (!sdone) begin
            if (wr && !no_rise) begin
                mcnt <= mcnt + 1;
                if (mcnt >= dly_hi) begin
                    sdone <= 1'b1;
                    mcnt  <= 0;
                    mpul  <= 0;
                end
            end else begin
                mcnt <= 0;
            end
        end else if (!wr && sclk && !psclk && !no_fall) begin
            mpul <= mpul + 1;
            if (mpul + 1 >= npulse) sdone <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [L-1:0] rnd_cfg();
        logic [L-1:0] v = '0;
        for (int i = 0; i < (L + 31) / 32; i++) v = (v << 32) | L'($urandom());
        return v;
    endfunction

    function automatic logic [L:0] exp_stream(input logic [L-1:0] c);
        return {1'b0, c};
    endfunction

    task automatic prep(input int dly, input int np, input bit nr, input bit nf);
        dly_hi = dly; npulse = np; no_rise = nr; no_fall = nf;
        n_rise = 0; n_early_bad = 0; n_waitrise = 0; n_post = 0;
        rd_cnt = 0; done_cnt = 0; cap = '0;
    endtask

    task automatic wait_done(output bit seen);
        int k = 0;
        seen = 1'b0;
        while (!done && k < 5000) begin
            @(negedge clk);
            k++;
        end
        seen = done;
        chk(seen, "R5 command completes (done seen)", seen, 1);
        if (seen) begin
            chk(!busy, "R11 busy low with done", busy, 0);
            @(negedge clk);
            chk(!done, "R11 done single cycle", done, 0);
        end
    endtask

    task automatic run_load(input logic [L-1:0] c, input int dly, input int np,
                            input bit both, input bit poke);
        logic [L:0] expv;
        bit seen;
        prep(dly, np, 1'b0, 1'b0);
        expv = exp_stream(c);
        @(negedge clk);
        cfg = c; load = 1'b1; rw = both;
        @(negedge clk);
        load = 1'b0; rw = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            cfg = ~c; load = 1'b1; rw = 1'b1;
            @(negedge clk);
            load = 1'b0; rw = 1'b0;
        end
        wait_done(seen);
        chk(n_rise == L + 1, "R2 bit count", n_rise, L + 1);
        chk(cap == expv, "R2 leading zero then MSB-first data", cap[31:0], expv[31:0]);
        chk(n_early_bad == 1, "R2 read high before final edge", n_early_bad, 1);
        chk(!fin_rd && fin_wr, "R3 write replaces read at final edge", {fin_rd, fin_wr}, 2'b01);
        chk(n_waitrise == 1, "R4 no scan clock while waiting for done", n_waitrise, 1);
        chk(n_post == np, "R5 pulses until done falls", n_post, np);
        chk(!err, "R7 no error on normal load", err, 0);
        chk(rise_t1 - rise_t0 == 2 * HALF, "R10 scan clock period", rise_t1 - rise_t0, 2 * HALF);
        if (poke || both) begin
            chk(done_cnt == 1, "R8 R9 single command performed", done_cnt, 1);
        end
    endtask

    task automatic run_rewrite(input int dly, input int np);
        bit seen;
        prep(dly, np, 1'b0, 1'b0);
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
        rw = 1'b0;
        chk(wr && !rd, "R6 write raised alone", {rd, wr}, 2'b01);
        wait_done(seen);
        chk(n_rise == 0 && rd_cnt == 0, "R6 no shifting on rewrite", n_rise + rd_cnt, 0);
        chk(n_post == np, "R6 completes after done falls", n_post, np);
        chk(!err, "R6 no error", err, 0);
    endtask

    task automatic run_timeout(input bit nr, input bit nf);
        bit seen;
        prep(10, 3, nr, nf);
        tmo = 16'd60;
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
        rw = 1'b0;
        wait_done(seen);
        chk(err, nf ? "R7 timeout waiting for done to fall" : "R7 timeout waiting for done to rise", err, 1);
        chk(!wr && !sclk, "R7 outputs released on timeout", {wr, sclk}, 0);
        @(negedge clk);
        sdone = 1'b0;
        no_rise = 1'b0;
        no_fall = 1'b0;
        tmo = 16'd2000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog act=hung exp=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R1 status after reset", {busy, done, err}, 0);
        chk(!sclk && !rd && !wr, "R1 scan pins after reset", {sclk, rd, wr}, 0);

        run_load({L{1'b1}}, 12, 1, 1'b0, 1'b0);
        run_load({1'b1, {(L-1){1'b0}}}, 9, 5, 1'b0, 1'b0);
        run_rewrite(8, 4);
        // R9: both strobes on the same idle edge
        run_load(rnd_cfg(), 15, 2, 1'b1, 1'b0);
        // R8: strobes and cfg change while busy
        run_load(rnd_cfg(), 10, 3, 1'b0, 1'b1);
        run_timeout(1'b1, 1'b0);
        // R7: err clears on the next accepted load
        run_load(rnd_cfg(), 10, 2, 1'b0, 1'b0);
        run_timeout(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) begin
            run_load(rnd_cfg(), 8 + int'($urandom_range(0, 30)),
                     1 + int'($urandom_range(0, 6)), 1'b0, 1'b0);
            run_rewrite(8 + int'($urandom_range(0, 20)), 1 + int'($urandom_range(0, 5)));
        end
        summary();
    end
endmodule